// File: doc/BRIEF.md
# Gated Sync-Pulse Rate Counter

This block measures how many horizontal sync pulses arrive within a gate interval. At the end of each interval it stores the running count in a 10-bit result register and starts the next interval from zero. The gate interval is either one of four fixed periods taken from a free-running prescaler, or the time between two active edges on one of two external inputs: a general video input or the vertical sync input.

There are two channels that work independently. Each has its own gate-select register and its own result register. Both channels count the same horizontal sync input. A small register port lets a CPU program the selects and read the latest results at any time. A single enable input turns the whole block on or off. While it is off, the running state is held at zero and the last results are kept.

The fixed gate periods are counted in prescaler ticks, which arrive on a one-cycle strobe input. The size of the shortest period is set by a parameter. The default gives about 1 ms when the tick comes once per microsecond.

Top module: `sync_rate_counter`

## Requirements
- R1: Each rising edge of the horizontal sync input that is detected during an interval adds one to the running count. At the end of the interval the count is written to that channel's result register, and the running count restarts at zero.
- R2: Select codes 0 to 3 give a fixed gate of 2^(BASE_LOG2+code) prescaler ticks. The prescaler advances only on cycles where presc_tick is high. It starts from zero when the block is enabled, so the first gate comes after one full period.
- R3: Select code 4 gates on rising edges of video_in. Code 5 gates on rising edges of vsync_in. Codes 6 and 7 never end an interval, so the result register is not updated.
- R4: The running count saturates at 0x3FF and does not wrap. An interval that has 1023 or more edges reports 0x3FF.
- R5: Register map on reg_addr. Address 0 is the channel 0 select and address 1 is the channel 1 select; both are written from reg_wdata[2:0] and read back in bits 2:0. Address 2 is the channel 0 result and address 3 is the channel 1 result, both in bits 9:0. The result addresses are read-only, so writes to them are ignored. reg_rdata is a combinational read of the addressed register. All unused bits read as zero.
- R6: The two channels run independently. A gate on one channel does not change the other channel's result.
- R7: While cnt_en is low, the prescaler and the running counts are held at zero. No result is written, and the result registers keep their values.
- R8: If a horizontal sync edge is detected in the same cycle that an interval ends, that edge is included in the value written for the interval that is ending. The new interval starts from zero.
- R9: In the external gate modes, after enable or after a write to the select register, the first active edge only starts an interval. No result is written until the next active edge.
- R10: All three sync inputs pass through two synchronising flip-flops. The active edge is a rising edge of the synchronised signal. Writing a select register clears that channel's running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Block enable |
| presc_tick | input | 1 | One-cycle prescaler strobe |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| video_in | input | 1 | General video gate input, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |

## Verification
The fixed-period modes are driven with a free-running horizontal sync of several periods and with two tick rates. Each expected count is the gate length divided by the sync period, so this separates the four codes from each other and shows that the prescaler only advances on tick cycles. The external modes are driven with random bursts of sync pulses between gate edges, which separates counting from arming and shows that pulses before the first edge are left out. Directed cases cover these points:
- a sync edge arriving together with a gate edge;
- a dense sync stream that saturates the count;
- pulses sent while the block is disabled;
- the unused select codes;
- both channels running at once on different gate sources.

// File: rtl/src_pkg.sv
package src_pkg;

    localparam int CNT_W     = 10;
    localparam int NUM_CH    = 2;
    localparam int NUM_FIXED = 4;
    localparam int RD_W      = 16;
    localparam int WD_W      = 8;

    typedef enum logic [2:0] {
        GS_FIX0  = 3'd0,
        GS_FIX1  = 3'd1,
        GS_FIX2  = 3'd2,
        GS_FIX3  = 3'd3,
        GS_VIDEO = 3'd4,
        GS_VSYNC = 3'd5,
        GS_OFF6  = 3'd6,
        GS_OFF7  = 3'd7
    } gate_src_e;

    typedef enum logic [1:0] {
        RA_SEL0 = 2'd0,
        RA_SEL1 = 2'd1,
        RA_RES0 = 2'd2,
        RA_RES1 = 2'd3
    } reg_addr_e;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic vid;
    } sync_vec_t;

    function automatic count_t sat_inc(count_t v, logic inc);
        if (v == '1) return v;
        return v + {{(CNT_W-1){1'b0}}, inc};
    endfunction

    function automatic logic is_external(gate_src_e s);
        return (s == GS_VIDEO) || (s == GS_VSYNC);
    endfunction

endpackage

// File: rtl/src_edge_sync.sv
module src_edge_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_rise
            assign rise[i] = sync_q[i] & ~prev_q[i];
        end
    endgenerate

    // R10: a detected rising edge lasts exactly one cycle
    p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/src_prescaler.sv
module src_prescaler
    import src_pkg::*;
#(
    parameter int BASE_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    output logic [NUM_FIXED-1:0] gate
);
    localparam int PW = BASE_LOG2 + NUM_FIXED;

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_FIXED; k++) begin : g_gate
            assign gate[k] = tick & (&pcnt_q[BASE_LOG2+k-1:0]);
        end
    endgenerate

    // R7: prescaler held at zero while disabled
    p_presc_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pcnt_q == '0));

    // R2: prescaler only moves on tick cycles
    p_presc_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (pcnt_q == $past(pcnt_q)) || !$past(en));

endmodule

// File: rtl/src_channel.sv
module src_channel
    import src_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 sel_wr,
    input  gate_src_e            sel_wdata,
    input  logic [NUM_FIXED-1:0] fixed_gate,
    input  logic                 hs_rise,
    input  logic                 vs_rise,
    input  logic                 vid_rise,
    output gate_src_e            sel_q,
    output count_t               result
);
    count_t cnt_q;
    logic   armed_q;
    logic   fix_hit;
    logic   ext_hit;
    logic   gate_end;
    logic   count_ok;

    always_comb begin
        fix_hit = 1'b0;
        ext_hit = 1'b0;
        case (sel_q)
            GS_FIX0:  fix_hit = fixed_gate[0];
            GS_FIX1:  fix_hit = fixed_gate[1];
            GS_FIX2:  fix_hit = fixed_gate[2];
            GS_FIX3:  fix_hit = fixed_gate[3];
            GS_VIDEO: ext_hit = vid_rise;
            GS_VSYNC: ext_hit = vs_rise;
            default:  ;
        endcase
        gate_end = fix_hit | (ext_hit & armed_q);
        count_ok = !is_external(sel_q) || armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= GS_FIX0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            result  <= '0;
        end else begin
            if (sel_wr) sel_q <= sel_wdata;
            if (!en || sel_wr) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (gate_end) begin
                result <= sat_inc(cnt_q, hs_rise);
                cnt_q  <= '0;
            end else if (ext_hit) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (hs_rise && count_ok) begin
                cnt_q <= sat_inc(cnt_q, 1'b1);
            end
        end
    end

    // R1: running count restarts from zero after an interval ends
    p_clear_after_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (en && !sel_wr && gate_end) |=> (cnt_q == '0));

    // R4: saturated count never wraps within an interval
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !sel_wr && !gate_end && cnt_q == '1) |=> (cnt_q == '1));

    // R7: disabled block keeps results and holds the count at zero
    p_disabled_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(result) && cnt_q == '0));

    // R9: no result before the arming edge
    p_unarmed_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (is_external(sel_q) && !armed_q) |=> $stable(result));

    // R3: unused codes never update the result
    p_idle_code_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_q == GS_OFF6 || sel_q == GS_OFF7) |=> $stable(result));

    // R10: a select write clears the running count
    p_sel_wr_clear_r10: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (cnt_q == '0));

endmodule

// File: rtl/sync_rate_counter.sv
module sync_rate_counter
    import src_pkg::*;
#(
    parameter int BASE_LOG2 = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_en,
    input  logic            presc_tick,
    input  logic            hsync_in,
    input  logic            vsync_in,
    input  logic            video_in,
    input  logic [1:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [WD_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata
);
    sync_vec_t            raw_v;
    sync_vec_t            rise_v;
    logic [NUM_FIXED-1:0] fixed_gate;
    logic [NUM_CH-1:0]    sel_wr;
    gate_src_e            sel_q  [NUM_CH];
    count_t               res_q  [NUM_CH];
    gate_src_e            wsel;

    assign raw_v.hs  = hsync_in;
    assign raw_v.vs  = vsync_in;
    assign raw_v.vid = video_in;
    assign wsel      = gate_src_e'(reg_wdata[2:0]);

    src_edge_sync #(.WIDTH(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_v),
        .rise (rise_v)
    );

    src_prescaler #(.BASE_LOG2(BASE_LOG2)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (cnt_en),
        .tick (presc_tick),
        .gate (fixed_gate)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign sel_wr[c] = reg_wr && (reg_addr == 2'(c));

            src_channel u_ch (
                .clk        (clk),
                .rst        (rst),
                .en         (cnt_en),
                .sel_wr     (sel_wr[c]),
                .sel_wdata  (wsel),
                .fixed_gate (fixed_gate),
                .hs_rise    (rise_v.hs),
                .vs_rise    (rise_v.vs),
                .vid_rise   (rise_v.vid),
                .sel_q      (sel_q[c]),
                .result     (res_q[c])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_SEL0: reg_rdata[2:0]       = sel_q[0];
            RA_SEL1: reg_rdata[2:0]       = sel_q[1];
            RA_RES0: reg_rdata[CNT_W-1:0] = res_q[0];
            RA_RES1: reg_rdata[CNT_W-1:0] = res_q[1];
            default: ;
        endcase
    end

    // R5: a write to a select address is reflected on read of that address
    p_sel_readback_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0) |=> (sel_q[0] == $past(wsel)));

endmodule

// File: tb/sync_rate_counter_tb_top.sv
module sync_rate_counter_tb_top;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        presc_tick;
    logic        hsync_in;
    logic        vsync_in = 1'b0;
    logic        video_in = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [15:0] reg_rdata;

    logic hs_man = 1'b0;
    logic hs_gen = 1'b0;
    int   hs_per = 0;
    int   hs_ph = 0;
    int   tick_div = 1;
    int   tick_ph = 0;
    int   checks = 0;
    int   errors = 0;

    always #5 clk = ~clk;

    assign hsync_in   = hs_gen | hs_man;
    assign presc_tick = (tick_ph == 0);

    always @(negedge clk) begin
        if (hs_per == 0) begin
            hs_ph  <= 0;
            hs_gen <= 1'b0;
        end else begin
            hs_ph  <= (hs_ph + 1 >= hs_per) ? 0 : hs_ph + 1;
            hs_gen <= (hs_ph < hs_per / 2);
        end
        tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    end

    sync_rate_counter #(.BASE_LOG2(BL)) dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .presc_tick(presc_tick),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .video_in(video_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic int exp_fixed(int code, int hp, int td);
        return ((1 << (BL + code)) * td) / hp;
    endfunction

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr  = 2'(a);
        reg_wdata = 8'(d);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        reg_addr = 2'(a);
        #1 v = int'(reg_rdata);
    endtask

    task automatic hs_pulses(int n);
        for (int i = 0; i < n; i++) begin
            hs_man = 1'b1; waitn(2);
            hs_man = 1'b0; waitn(2);
        end
    endtask

    task automatic vs_pulse();
        vsync_in = 1'b1; waitn(2);
        vsync_in = 1'b0; waitn(6);
    endtask

    task automatic vid_pulse();
        video_in = 1'b1; waitn(2);
        video_in = 1'b0; waitn(6);
    endtask

    task automatic set_en(logic e);
        @(negedge clk);
        cnt_en = e;
        waitn(2);
    endtask

    task automatic run_fixed(string tag, int code, int hp, int td);
        int v;
        set_en(1'b0);
        wr(0, code);
        hs_per   = hp;
        tick_div = td;
        set_en(1'b1);
        waitn(3 * (1 << (BL + code)) * td + 10);
        rd(2, v);
        check(tag, v, exp_fixed(code, hp, td));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v, saved, n, m, gap;
        void'($urandom(32'd4711));
        waitn(4);
        rst = 1'b0;

        // R5: reset state
        rd(2, v); check("R5 reset result0", v, 0);
        rd(3, v); check("R5 reset result1", v, 0);
        rd(0, v); check("R5 reset select0", v, 0);

        // R2: fixed periods, directed
        for (int c = 0; c < 4; c++) run_fixed("R2 fixed code", c, 4, 1);
        run_fixed("R2 tick every second cycle", 1, 4, 2);
        // R1/R2: random fixed cases
        for (int i = 0; i < 6; i++) begin
            int c  = int'($urandom_range(0, 3));
            int hp = 2 << $urandom_range(0, 3);
            int td = int'($urandom_range(1, 2));
            run_fixed("R1 random fixed", c, hp, td);
        end

        // R6: ch0 on vsync, ch1 fixed code 0, shared hsync
        set_en(1'b0);
        wr(0, 5); wr(1, 0);
        hs_per = 4; tick_div = 1;
        set_en(1'b1);
        for (int i = 0; i < 3; i++) begin
            gap = 4 * int'($urandom_range(20, 200));
            vsync_in = 1'b1; waitn(2); vsync_in = 1'b0; waitn(gap - 2);
            vsync_in = 1'b1; waitn(2); vsync_in = 1'b0; waitn(8);
            rd(2, v); check("R6 ch0 vsync gate", v, gap / 4);
            rd(3, v); check("R6 ch1 fixed gate", v, exp_fixed(0, 4, 1));
        end
        hs_per = 0;

        // R9: arming in external mode
        set_en(1'b0);
        set_en(1'b1);
        waitn(4);
        rd(2, saved);
        hs_pulses(4);
        vs_pulse();
        rd(2, v); check("R9 no latch on arming edge", v, saved);
        for (int i = 0; i < 4; i++) begin
            n = int'($urandom_range(1, 40));
            hs_pulses(n);
            vs_pulse();
            rd(2, v); check("R1 external burst count", v, n);
        end

        // R3/R6: ch1 on video, ch0 on vsync
        wr(1, 4);
        vid_pulse();
        hs_pulses(3);
        vid_pulse();
        rd(3, v); check("R3 video gate ch1", v, 3);
        hs_pulses(2);
        vs_pulse();
        rd(2, v); check("R3 vsync gate ch0", v, 5);
        rd(3, v); check("R6 ch1 untouched by vsync", v, 3);
        vid_pulse();
        rd(3, v); check("R3 video gate ch1 second", v, 2);

        // R8: hsync edge together with gate end
        n = 6;
        hs_pulses(n);
        @(negedge clk);
        hs_man = 1'b1; vsync_in = 1'b1; waitn(2);
        hs_man = 1'b0; vsync_in = 1'b0; waitn(8);
        rd(2, v); check("R8 coincident edge counted", v, n + 1);
        hs_pulses(3);
        vs_pulse();
        rd(2, v); check("R8 next interval from zero", v, 3);

        // R4: saturation
        hs_per = 2;
        vs_pulse();
        waitn(2200);
        vs_pulse();
        rd(2, v); check("R4 saturates at 0x3FF", v, 1023);
        hs_per = 0;
        waitn(4);
        vs_pulse();
        hs_pulses(5);
        vs_pulse();
        rd(2, v); check("R4 restart after saturation", v, 5);

        // R7: disabled hold
        set_en(1'b0);
        vs_pulse(); hs_pulses(3); vs_pulse();
        rd(2, v); check("R7 result held while disabled", v, 5);
        set_en(1'b1);
        vs_pulse(); hs_pulses(4); vs_pulse();
        rd(2, v); check("R7 counting after re-enable", v, 4);

        // R10: select write clears running count
        hs_pulses(7);
        wr(0, 5);
        vs_pulse(); hs_pulses(2); vs_pulse();
        rd(2, v); check("R10 select write restarts", v, 2);

        // R3/R5: unused code and read-only results
        wr(1, 6);
        rd(1, v); check("R5 select1 readback", v, 6);
        rd(3, saved);
        hs_per = 4;
        vid_pulse(); vs_pulse(); waitn(300); vid_pulse();
        rd(3, v); check("R3 code 6 never latches", v, saved);
        hs_per = 0;
        wr(3, 8'h55);
        rd(3, v); check("R5 result write ignored", v, saved);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule